// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Error Detection

This block turns characters arriving on an asynchronous serial line into bytes. It runs from the system clock. A separate enable input, pulsing sixteen times per bit period, sets the timing. The host supplies the character shape: the number of data bits, whether a parity bit is present, and whether parity is odd or even. These are the same settings the matching transmitter uses.

Each completed character goes into a one-deep holding buffer, and a ready flag marks that it has not yet been read. Along with the byte, the block reports four conditions:

- a parity mismatch,
- a missing stop bit,
- a line held in the spacing state for a whole character (a break),
- a character lost because the buffer was not read in time (overrun).

These error flags stay set until the host pulses a status-read strobe. A separate buffer-read strobe retires the byte.

Top module: `uart_rx_deser`

## Requirements
- R1: Data bits arrive least significant bit first. The length code `cfg_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `rx_data` above the selected length read as 0.
- R2: The receiver starts a character on the first enable tick that sees the synchronized line low. It confirms the start bit at the eighth tick, which is the bit mid-point. After that it samples each following bit once every 16 ticks.
- R3: `err_frame` is set when the first stop bit is sampled low. Only that one stop bit is examined, so a new start bit may follow it directly.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_even` = 1 means the data plus parity must hold an even number of ones; 0 means an odd number. `err_parity` is set only when parity is enabled and that count is wrong.
- R5: A character whose data, parity and stop bits all sample as 0 sets both `err_break` and `err_frame`, and loads `rx_data` with 0. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: If a character completes while `rx_ready` is 1 and no `buf_rd` arrives in the same cycle, the new byte replaces the old one and `err_overrun` is set.
- R7: `rx_ready` and the new `rx_data` appear one clock after the stop-bit sample. After reset every output is 0.
- R8: A one-cycle `stat_rd` pulse clears all four error flags one clock later. A flag being set in the same cycle takes priority over the clear. `stat_rd` does not change `rx_ready` or `rx_data`.
- R9: A one-cycle `buf_rd` pulse clears `rx_ready` one clock later, unless a character completes in that same cycle.
- R10: If the line is high again at the start-bit mid-point, the low pulse is discarded. No character and no flag results, and the receiver returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| buf_rd | input | 1 | Host read of the holding buffer |
| stat_rd | input | 1 | Host read of status; clears error flags |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Buffer holds an unread character |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_break | output | 1 | Sticky break indication |
| err_overrun | output | 1 | Sticky overrun |

## Verification
The assertions assume that the line-control inputs stay steady while a character is in flight. They also assume that `buf_rd` and `stat_rd` are single-cycle pulses. The stimulus meets both conditions: it changes the configuration only while the line idles between characters, and it pulses each strobe for exactly one clock. It also drives every bit for a whole number of 16-tick periods, with ticks arriving every second clock. This keeps each sampling point well inside its bit, even after the two-clock synchronizer delay.

// File: rtl/rxd_pkg.sv
// Shared definitions for the serial receiver.
// Assumes: characters carry at most BYTE_W data bits.
package rxd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_result_t;
endpackage

// File: rtl/rxd_sync.sv
// Two-flop synchronizer for the asynchronous serial line.
// Assumes: the line idles high, so both stages reset to 1.
module rxd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic line
);
    logic meta_q;
    logic sync_q;

    // Move the input into the clock domain through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign line = sync_q;
endmodule

// File: rtl/rxd_frame.sv
// Character framer: finds the start bit, samples each bit at its
// mid-point and checks parity, stop bit and break.
// Assumes: configuration is steady during a character; tick occurs
// OVS times per bit period.
module rxd_frame
    import rxd_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    output logic       done,
    output rx_result_t result
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int IW   = $clog2(BYTE_W);

    rx_state_e         state_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              par_q;
    logic              at_mid;
    logic              at_bit;
    logic [IW-1:0]     last_idx;
    logic              perr_w;
    logic              brk_w;

    // Sampling points derived from the tick counter.
    assign at_mid   = tick && (cnt_q == CW'(HALF - 1));
    assign at_bit   = tick && (cnt_q == CW'(OVS - 1));
    assign last_idx = IW'(cfg_len) + IW'(4);

    // Parity and break judgement for the character now in the shifter.
    assign perr_w = cfg_par_en && ((^shreg_q) ^ par_q ^ ~cfg_par_even);
    assign brk_w  = !line && (shreg_q == '0) && !(cfg_par_en && par_q);

    // Frame state machine with per-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (tick && !line) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                    end
                end
                ST_START: begin
                    if (at_mid) begin
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        shreg_q <= '0;
                        par_q   <= 1'b0;
                        state_q <= line ? ST_IDLE : ST_DATA;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (at_bit) begin
                        cnt_q          <= '0;
                        shreg_q[idx_q] <= line;
                        if (idx_q == last_idx) begin
                            state_q <= cfg_par_en ? ST_PAR : ST_STOP;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_bit) begin
                        cnt_q   <= '0;
                        par_q   <= line;
                        state_q <= ST_STOP;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_bit) begin
                        cnt_q       <= '0;
                        done        <= 1'b1;
                        result.data <= shreg_q;
                        result.perr <= perr_w;
                        result.ferr <= !line;
                        result.brk  <= brk_w;
                        state_q     <= line ? ST_IDLE : ST_HOLD;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (line) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxd_status.sv
// Holding buffer and sticky error flags seen by the host.
// Assumes: done is a one-cycle pulse; strobes are one-cycle pulses.
module rxd_status
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  rx_result_t        result,
    input  logic              buf_rd,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_break,
    output logic              err_overrun
);
    logic lost_w;

    // A character is lost when the previous one is still unread.
    assign lost_w = done && rx_ready && !buf_rd;

    // Buffer load and ready flag; a new character wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else if (done) begin
            rx_data  <= result.data;
            rx_ready <= 1'b1;
        end else if (buf_rd) begin
            rx_ready <= 1'b0;
        end
    end

    // Sticky error flags; setting wins over the status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_break   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            err_parity  <= (done && result.perr) || (err_parity  && !stat_rd);
            err_frame   <= (done && result.ferr) || (err_frame   && !stat_rd);
            err_break   <= (done && result.brk)  || (err_break   && !stat_rd);
            err_overrun <= lost_w                || (err_overrun && !stat_rd);
        end
    end
endmodule

// File: rtl/uart_rx_deser.sv
// Top of the serial receiver: synchronizer, framer and host status.
// Assumes: tick16 pulses OVS times per bit period, one clock wide.
module uart_rx_deser
    import rxd_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_serial,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              buf_rd,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_break,
    output logic              err_overrun
);
    logic       line_w;
    logic       frame_done;
    rx_result_t frame_res;

    rxd_sync i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_serial),
        .line  (line_w)
    );

    rxd_frame #(.OVS(OVS)) i_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick16),
        .line         (line_w),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .done         (frame_done),
        .result       (frame_res)
    );

    rxd_status i_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (frame_done),
        .result      (frame_res),
        .buf_rd      (buf_rd),
        .stat_rd     (stat_rd),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_break   (err_break),
        .err_overrun (err_overrun)
    );
endmodule

// File: rtl/uart_rx_deser_chk.sv
// Property checker for the serial receiver, bound to the top module.
// Assumes: configuration steady within a character, strobes one cycle.
module uart_rx_deser_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic cfg_par_en,
    input logic buf_rd,
    input logic stat_rd,
    input logic rx_ready,
    input logic err_parity,
    input logic err_frame,
    input logic err_break,
    input logic err_overrun
);
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_ready); // R7

    AST_LOST_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_ready && !buf_rd) |=> err_overrun); // R6

    AST_BREAK_IMPLIES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        err_break |-> err_frame); // R5

    AST_PARITY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_parity) |-> $past(cfg_par_en)); // R4

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !done) |=> (!err_parity && !err_frame && !err_break && !err_overrun)); // R8

    AST_BUFFER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !done) |=> !rx_ready); // R9

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !buf_rd) |=> rx_ready); // R9
endmodule

bind uart_rx_deser uart_rx_deser_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (frame_done),
    .cfg_par_en  (cfg_par_en),
    .buf_rd      (buf_rd),
    .stat_rd     (stat_rd),
    .rx_ready    (rx_ready),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_break   (err_break),
    .err_overrun (err_overrun)
);

// File: tb/test_uart_rx_deser.sv
// Bench: sweeps lengths, parity modes and data values, then error cases.
module test_uart_rx_deser;
    localparam int BITCLK = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_serial = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       buf_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_frame, err_break, err_overrun;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    // Tick every second clock: 16 ticks = 32 clocks per bit.
    always @(negedge clk) tick16 <= ~tick16;

    uart_rx_deser i_uart_rx_deser (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_serial(rx_serial),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .buf_rd(buf_rd), .stat_rd(stat_rd), .rx_data(rx_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
        .err_overrun(err_overrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int bits);
        rx_serial = v;
        repeat (bits * BITCLK) @(negedge clk);
    endtask

    // pm: 0 none, 1 odd, 2 even. flip inverts the parity bit.
    task automatic send_frame(input logic [7:0] d, input int nb, input int pm,
                              input bit flip, input logic stop_v);
        logic pb;
        hold_line(1'b0, 1);
        for (int i = 0; i < nb; i++) hold_line(d[i], 1);
        if (pm != 0) begin
            pb = ^d;
            if (pm == 1) pb = ~pb;
            if (flip) pb = ~pb;
            hold_line(pb, 1);
        end
        hold_line(stop_v, 1);
        rx_serial = 1'b1;
    endtask

    task automatic pulse_buf();
        buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_stat();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
    endtask

    task automatic set_cfg(input int len, input int pm);
        cfg_len      = 2'(len);
        cfg_par_en   = (pm != 0);
        cfg_par_even = (pm == 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Reset state: R7
        check("R7 reset ready", rx_ready, 0);
        check("R7 reset data", rx_data, 0);
        check("R7 reset errs", {err_parity, err_frame, err_break, err_overrun}, 0);
        hold_line(1'b1, 2);

        // Sweep lengths, parity modes and data values: R1 R2 R4 R7 R9
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int k = 0; k < 8; k++) begin
                    logic [7:0] mask;
                    logic [7:0] d;
                    mask = 8'((1 << (5 + len)) - 1);
                    d = 8'(k * 37 + len * 11 + pm * 5 + 13) & mask;
                    if (k == 7) d = mask;
                    set_cfg(len, pm);
                    send_frame(d, 5 + len, pm, 1'b0, 1'b1);
                    check("R1 R2 data", rx_data, d);
                    check("R7 ready", rx_ready, 1);
                    check("R4 no errs", {err_parity, err_frame, err_break, err_overrun}, 0);
                    pulse_buf();
                    check("R9 ready cleared", rx_ready, 0);
                    hold_line(1'b1, 1);
                end
            end
        end

        // Parity error, even and odd: R4, then clear: R8
        set_cfg(3, 2);
        send_frame(8'h3C, 8, 2, 1'b1, 1'b1);
        check("R4 even parity err", err_parity, 1);
        check("R4 no frame err", err_frame, 0);
        pulse_stat();
        check("R8 parity cleared", err_parity, 0);
        check("R8 ready untouched", rx_ready, 1);
        check("R8 data untouched", rx_data, 8'h3C);
        pulse_buf();
        set_cfg(1, 1);
        send_frame(8'h15, 6, 1, 1'b1, 1'b1);
        check("R4 odd parity err", err_parity, 1);
        pulse_stat();
        pulse_buf();
        hold_line(1'b1, 1);

        // Framing error without break: R3
        set_cfg(3, 0);
        send_frame(8'h55, 8, 0, 1'b0, 1'b0);
        check("R3 frame err", err_frame, 1);
        check("R3 no break", err_break, 0);
        check("R3 data kept", rx_data, 8'h55);
        pulse_stat();
        check("R8 frame cleared", err_frame, 0);
        pulse_buf();
        hold_line(1'b1, 2);

        // Break: line low for a whole character and beyond: R5
        set_cfg(3, 2);
        hold_line(1'b0, 14);
        hold_line(1'b1, 2);
        check("R5 break", err_break, 1);
        check("R5 frame with break", err_frame, 1);
        check("R5 data zero", rx_data, 0);
        pulse_buf();
        hold_line(1'b1, 2);
        check("R5 single char", rx_ready, 0);
        pulse_stat();
        check("R8 break cleared", err_break, 0);

        // Back-to-back characters without a read: R6, single stop check R3
        set_cfg(3, 0);
        send_frame(8'hA1, 8, 0, 1'b0, 1'b1);
        send_frame(8'h7E, 8, 0, 1'b0, 1'b1);
        check("R6 overrun", err_overrun, 1);
        check("R6 newest data", rx_data, 8'h7E);
        check("R3 no frame err back to back", err_frame, 0);
        pulse_stat();
        check("R8 overrun cleared", err_overrun, 0);
        pulse_buf();
        hold_line(1'b1, 1);

        // Short low glitch is rejected: R10
        rx_serial = 1'b0;
        repeat (6) @(negedge clk);
        rx_serial = 1'b1;
        repeat (200) @(negedge clk);
        check("R10 glitch ignored", rx_ready, 0);
        check("R10 no flags", {err_parity, err_frame, err_break, err_overrun}, 0);
        send_frame(8'hA5, 8, 0, 1'b0, 1'b1);
        check("R10 next char ok", rx_data, 8'hA5);
        check("R10 next ready", rx_ready, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule